// File: doc/BRIEF.md
# Shift Right Pair Funnel Unit

This execution unit carries out the shift-right-pair instruction of a 64-bit register machine. Two source registers are funnelled through one right shift. The first source is the high half and the second is the low half. The result comes either in word form (32 bits, zero-extended) or in doubleword form (64 bits). The shift amount comes from one of two places. It is either the machine's shift-amount register or an immediate bit position carried in the instruction word.

The unit decodes its own instruction fields. The register indices are decoded for two cases. A high-source index of 0 gives a zero-filled logical shift. Equal source indices give a rotate. The unit reports the destination index and the 3-bit condition field, so that the pipeline can evaluate nullification of the next instruction. When the parameter `ENABLE_WIDE` is 0, every doubleword form is flagged illegal and is not written. The inputs are taken with a valid strobe. All outputs are registered one cycle later.

Top module: `srp_funnel_unit`

## Requirements
- R1: A word form gives bits [31:0] of the 64-bit value {high[31:0], low[31:0]} shifted right by the amount. Bits [63:32] of the result are zero.
- R2: A word form that takes its amount from the shift-amount register uses only bits [4:0] of that register, so an input of 40 shifts by 8.
- R3: When the high-source index (instr[20:16]) is 0, the high source is all zeros and the high data input is ignored. This rule takes priority over R4. The result is then a logical right shift of the low source; in word form the low source is first cut to its bits [31:0].
- R4: When the two source indices are equal and nonzero, the low data input is used as both halves, so the result is a rotate right. In word form only bits [31:0] rotate.
- R5: A doubleword form that takes its amount from the shift-amount register uses all 6 bits, in the range 0 to 63. Its result is bits [63:0] of the 128-bit value {high, low} shifted right by that amount.
- R6: An immediate form shifts by width-1-pos, where width is 32 or 64. The word immediate form has instr[12:10]=010 and pos=instr[9:5]. The doubleword immediate form has instr[12]=0 and instr[10]=1, with pos={instr[11], instr[9:5]}.
- R7: The instruction is recognised when instr[31:26]=110100. In that case low index=instr[25:21], high index=instr[20:16], condition=instr[15:13] and destination=instr[4:0]. The register-amount form has instr[12:10]=000 and instr[8:5]=0000, and instr[9]=1 selects doubleword. Any other word presented with the valid strobe gives no output valid and no write.
- R8: With ENABLE_WIDE=0, a recognised doubleword form gives illegal=1, write=0 and result=0. Word forms are still executed.
- R9: For every recognised instruction, the destination index and the condition field appear on the outputs together with the result.
- R10: The outputs appear exactly one cycle after the input strobe. After reset, valid, write, illegal and result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Instruction strobe |
| inInstr | input | 32 | Instruction word |
| inHighData | input | 64 | Value of the register named by the high index |
| inLowData | input | 64 | Value of the register named by the low index |
| inSar | input | 6 | Shift-amount register |
| outValid | output | 1 | A recognised instruction completed |
| outWrite | output | 1 | Result should be written to outDest |
| outIllegal | output | 1 | Doubleword form on a word-only configuration |
| outResult | output | 64 | Shift result |
| outDest | output | 5 | Destination register index |
| outCond | output | 3 | Condition field for nullification |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle link from strobe to valid;
- the condition field lining up with the instruction that produced it;
- an illegal result never being written and always being zero;
- the upper half of every word-form result being zero.

The bench scenarios cover the arithmetic against a model built on a 128-bit shift:
- the 5-bit masking of the register amount;
- the priority of the zero-index high source over the equal-index rotate;
- the position-to-amount conversion at both ends of the position range;
- the decode of the sixth position bit;
- the rejection of words that are not a form of this instruction.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int POS_W = 6;

  typedef struct packed {
    logic             active;
    logic             illegal;
    logic             dword;
    logic             useSar;
    logic             zeroHigh;
    logic             sameSrc;
    logic [POS_W-1:0] pos;
  } srp_ctrl_t;
endpackage

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter bit ENABLE_WIDE = 1'b1,
  parameter int INSTR_W     = 32,
  parameter int IDX_W       = 5,
  parameter int COND_W      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] inInstr,
  output srp_ctrl_t          ctrlStb,
  output logic               outValid,
  output logic               outWrite,
  output logic               outIllegal,
  output logic [IDX_W-1:0]   outDest,
  output logic [COND_W-1:0]  outCond
);
  localparam logic [5:0] MAJOR_OP = 6'b110100;

  logic             opMatch, sarForm, immWord, immDword, recognized, isDword;
  logic [IDX_W-1:0] highIdx, lowIdx, destIdx;
  logic [COND_W-1:0] condField;

  always_comb begin
    opMatch    = inInstr[31:26] == MAJOR_OP;
    lowIdx     = inInstr[25:21];
    highIdx    = inInstr[20:16];
    condField  = inInstr[15:13];
    destIdx    = inInstr[4:0];
    sarForm    = (inInstr[12:10] == 3'b000) && (inInstr[8:5] == 4'b0000);
    immWord    = inInstr[12:10] == 3'b010;
    immDword   = !inInstr[12] && inInstr[10];
    recognized = inValid && opMatch && (sarForm || immWord || immDword);
    isDword    = sarForm ? inInstr[9] : immDword;

    ctrlStb.active   = recognized;
    ctrlStb.illegal  = recognized && isDword && !ENABLE_WIDE;
    ctrlStb.dword    = isDword;
    ctrlStb.useSar   = sarForm;
    ctrlStb.zeroHigh = highIdx == '0;
    ctrlStb.sameSrc  = highIdx == lowIdx;
    ctrlStb.pos      = immDword ? {inInstr[11], inInstr[9:5]} : {1'b0, inInstr[9:5]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      outWrite   <= 1'b0;
      outIllegal <= 1'b0;
      outDest    <= '0;
      outCond    <= '0;
    end else begin
      outValid   <= recognized;
      outWrite   <= recognized && !ctrlStb.illegal;
      outIllegal <= ctrlStb.illegal;
      if (recognized) begin
        outDest <= destIdx;
        outCond <= condField;
      end
    end
  end

  // R10: an output valid is always preceded by an input strobe
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid));

  // R9: the condition reported is the one of the instruction just taken
  p_cond_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outCond == $past(inInstr[15:13]));

  // R8: an illegal instruction is never written
  p_illegal_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outIllegal |-> (outValid && !outWrite));
endmodule

// File: rtl/srp_datapath.sv
module srp_datapath
  import srp_pkg::*;
#(
  parameter bit ENABLE_WIDE = 1'b1,
  parameter int DATA_W      = 64,
  parameter int SAR_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  srp_ctrl_t         ctrlStb,
  input  logic [DATA_W-1:0] highData,
  input  logic [DATA_W-1:0] lowData,
  input  logic [SAR_W-1:0]  sar,
  output logic [DATA_W-1:0] result
);
  localparam int WORD_W = DATA_W / 2;
  localparam int SH_W   = $clog2(DATA_W);
  localparam logic [SH_W-1:0] DW_TOP = SH_W'(DATA_W - 1);
  localparam logic [SH_W-2:0] W_TOP  = (SH_W-1)'(WORD_W - 1);

  logic [SH_W-1:0]   amount;
  logic [DATA_W-1:0] hiSrc, loSrc, wordCat, wordRes, dwordRes, nextRes;
  logic              resActive, resDword, resIllegal;

  always_comb begin
    if (ctrlStb.useSar)
      amount = ctrlStb.dword ? sar[SH_W-1:0] : {1'b0, sar[SH_W-2:0]};
    else if (ctrlStb.dword)
      amount = DW_TOP - ctrlStb.pos[SH_W-1:0];
    else
      amount = {1'b0, W_TOP - ctrlStb.pos[SH_W-2:0]};
  end

  always_comb begin
    loSrc = lowData;
    if (ctrlStb.zeroHigh)     hiSrc = '0;
    else if (ctrlStb.sameSrc) hiSrc = lowData;
    else                      hiSrc = highData;
  end

  always_comb begin
    wordCat = {hiSrc[WORD_W-1:0], loSrc[WORD_W-1:0]} >> amount[SH_W-2:0];
    wordRes = {{WORD_W{1'b0}}, wordCat[WORD_W-1:0]};
  end

  generate
    if (ENABLE_WIDE) begin : g_wide
      always_comb
        dwordRes = (loSrc >> amount) | ((hiSrc << (DW_TOP - amount)) << 1);
    end else begin : g_narrow
      always_comb dwordRes = '0;
    end
  endgenerate

  always_comb begin
    if (ctrlStb.illegal)    nextRes = '0;
    else if (ctrlStb.dword) nextRes = dwordRes;
    else                    nextRes = wordRes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      resActive  <= 1'b0;
      resDword   <= 1'b0;
      resIllegal <= 1'b0;
    end else begin
      resActive  <= ctrlStb.active;
      resDword   <= ctrlStb.dword;
      resIllegal <= ctrlStb.illegal;
      if (ctrlStb.active) result <= nextRes;
    end
  end

  // R1: a word-form result has a zero upper half
  p_word_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (resActive && !resDword) |-> result[DATA_W-1:WORD_W] == '0);

  // R8: an illegal form leaves a zero result
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resActive && resIllegal) |-> result == '0);
endmodule

// File: rtl/srp_funnel_unit.sv
module srp_funnel_unit
  import srp_pkg::*;
#(
  parameter bit ENABLE_WIDE = 1'b1,
  parameter int DATA_W      = 64,
  parameter int INSTR_W     = 32,
  parameter int IDX_W       = 5,
  parameter int COND_W      = 3,
  parameter int SAR_W       = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] inInstr,
  input  logic [DATA_W-1:0]  inHighData,
  input  logic [DATA_W-1:0]  inLowData,
  input  logic [SAR_W-1:0]   inSar,
  output logic               outValid,
  output logic               outWrite,
  output logic               outIllegal,
  output logic [DATA_W-1:0]  outResult,
  output logic [IDX_W-1:0]   outDest,
  output logic [COND_W-1:0]  outCond
);
  srp_ctrl_t ctrlStb;

  srp_ctrl #(
    .ENABLE_WIDE(ENABLE_WIDE), .INSTR_W(INSTR_W), .IDX_W(IDX_W), .COND_W(COND_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inInstr(inInstr),
    .ctrlStb(ctrlStb), .outValid(outValid), .outWrite(outWrite),
    .outIllegal(outIllegal), .outDest(outDest), .outCond(outCond)
  );

  srp_datapath #(
    .ENABLE_WIDE(ENABLE_WIDE), .DATA_W(DATA_W), .SAR_W(SAR_W)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .ctrlStb(ctrlStb), .highData(inHighData),
    .lowData(inLowData), .sar(inSar), .result(outResult)
  );
endmodule

// File: tb/srp_funnel_unit_bench.sv
module srp_funnel_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inInstr = '0;
  logic [63:0] inHighData = '0, inLowData = '0;
  logic [5:0]  inSar = '0;

  logic        wValid, wWrite, wIllegal, nValid, nWrite, nIllegal;
  logic [63:0] wResult, nResult;
  logic [4:0]  wDest, nDest;
  logic [2:0]  wCond, nCond;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  srp_funnel_unit #(.ENABLE_WIDE(1'b1)) u_srp_funnel_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inInstr(inInstr),
    .inHighData(inHighData), .inLowData(inLowData), .inSar(inSar),
    .outValid(wValid), .outWrite(wWrite), .outIllegal(wIllegal),
    .outResult(wResult), .outDest(wDest), .outCond(wCond));

  srp_funnel_unit #(.ENABLE_WIDE(1'b0)) u_srp_funnel_unit_narrow (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inInstr(inInstr),
    .inHighData(inHighData), .inLowData(inLowData), .inSar(inSar),
    .outValid(nValid), .outWrite(nWrite), .outIllegal(nIllegal),
    .outResult(nResult), .outDest(nDest), .outCond(nCond));

  function automatic logic [31:0] encSar(input int lo, hi, c, d, t);
    return {6'b110100, 5'(lo), 5'(hi), 3'(c), 3'b000, 1'(d), 4'b0000, 5'(t)};
  endfunction
  function automatic logic [31:0] encImmW(input int lo, hi, c, pos, t);
    return {6'b110100, 5'(lo), 5'(hi), 3'(c), 3'b010, 5'(pos), 5'(t)};
  endfunction
  function automatic logic [31:0] encImmD(input int lo, hi, c, pos, t);
    logic [5:0] p = 6'(pos);
    return {6'b110100, 5'(lo), 5'(hi), 3'(c), 1'b0, p[5], 1'b1, p[4:0], 5'(t)};
  endfunction

  // Behavioural reference from the requirements
  task automatic model(input logic [31:0] ins, input logic [63:0] hd, ld,
                       input logic [5:0] s, output bit rec, output bit dw,
                       output logic [63:0] res);
    int amt;
    logic [63:0] hi, lo;
    logic [127:0] cat;
    bit sarF, immW, immD;
    sarF = ins[12:10] == 3'b000 && ins[8:5] == 4'b0;
    immW = ins[12:10] == 3'b010;
    immD = ins[12] == 1'b0 && ins[10] == 1'b1;
    rec  = ins[31:26] == 6'b110100 && (sarF || immW || immD);
    dw   = sarF ? ins[9] : immD;
    if (sarF) amt = dw ? int'(s) : int'(s) % 32;
    else if (dw) amt = 63 - int'({ins[11], ins[9:5]});
    else amt = 31 - int'(ins[9:5]);
    lo = ld;
    if (ins[20:16] == 0) hi = 0;
    else if (ins[20:16] == ins[25:21]) hi = ld;
    else hi = hd;
    if (dw) begin
      cat = {hi, lo} >> amt;
      res = cat[63:0];
    end else begin
      cat = {64'b0, hi[31:0], lo[31:0]} >> amt;
      res = {32'b0, cat[31:0]};
    end
  endtask

  task automatic compareOne(input string tag, input string inst, input bit eRec,
      input bit eIll, input logic [63:0] eRes, input logic [31:0] ins,
      input logic v, w, il, input logic [63:0] r, input logic [4:0] d,
      input logic [2:0] c);
    bit ok;
    checks++;
    if (!eRec) ok = (v == 1'b0) && (w == 1'b0);
    else ok = v && (w == !eIll) && (il == eIll) && (r == eRes)
              && (d == ins[4:0]) && (c == ins[15:13]);
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s]: valid=%0b write=%0b illegal=%0b result=%h dest=%0d cond=%0d expected valid=%0b illegal=%0b result=%h dest=%0d cond=%0d",
               tag, inst, v, w, il, r, d, c, eRec, eIll, eRes, ins[4:0], ins[15:13]);
    end
  endtask

  task automatic step(input string tag, input logic [31:0] ins,
                      input logic [63:0] hd, ld, input logic [5:0] s);
    bit rec, dw;
    logic [63:0] res;
    @(negedge clk);
    inValid = 1'b1; inInstr = ins; inHighData = hd; inLowData = ld; inSar = s;
    model(ins, hd, ld, s, rec, dw, res);
    @(posedge clk); #1;
    compareOne(tag, "wide", rec, 1'b0, res, ins, wValid, wWrite, wIllegal, wResult, wDest, wCond);
    compareOne(tag, "narrow", rec, dw, dw ? 64'd0 : res, ins, nValid, nWrite, nIllegal, nResult, nDest, nCond);
  endtask

  localparam logic [63:0] A = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] B = 64'h0123_4567_89AB_CDEF;

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog: run did not finish, actual cycles=%0d expected fewer", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (wValid || wWrite || wIllegal || wResult != 0 || nValid || nResult != 0) begin
      fails++;
      $display("FAIL R10 reset: valid=%0b write=%0b illegal=%0b result=%h expected all zero",
               wValid, wWrite, wIllegal, wResult);
    end
    @(negedge clk) rst_n = 1'b1;

    step("R1 R7 word sar=8",        encSar(4, 3, 0, 0, 9),  A, B, 6'd8);
    step("R1 word sar=0",           encSar(4, 3, 1, 0, 9),  A, B, 6'd0);
    step("R2 word sar=40 masked",   encSar(4, 3, 0, 0, 9),  A, B, 6'd40);
    step("R2 word sar=31",          encSar(4, 3, 0, 0, 9),  A, B, 6'd31);
    step("R2 word sar=63 masked",   encSar(4, 3, 0, 0, 9),  A, B, 6'd63);
    step("R3 word zero high",       encSar(4, 0, 0, 0, 2),  A, B, 6'd4);
    step("R3 dword zero high",      encSar(4, 0, 0, 1, 2),  A, B, 6'd20);
    step("R3 zero idx over rotate", encSar(0, 0, 0, 0, 2),  A, B, 6'd4);
    step("R4 word rotate",          encSar(5, 5, 0, 0, 6),  A, B, 6'd12);
    step("R4 dword rotate",         encSar(5, 5, 0, 1, 6),  A, B, 6'd36);
    step("R5 dword sar=0",          encSar(4, 3, 0, 1, 7),  A, B, 6'd0);
    step("R5 dword sar=63",         encSar(4, 3, 0, 1, 7),  A, B, 6'd63);
    step("R5 dword sar=37",         encSar(4, 3, 0, 1, 7),  A, B, 6'd37);
    step("R6 imm word pos=31",      encImmW(4, 3, 0, 31, 8), A, B, 6'd5);
    step("R6 imm word pos=0",       encImmW(4, 3, 0, 0, 8),  A, B, 6'd5);
    step("R6 imm word pos=13",      encImmW(4, 0, 0, 13, 8), A, B, 6'd5);
    step("R6 imm dword pos=63",     encImmD(4, 3, 0, 63, 8), A, B, 6'd5);
    step("R6 imm dword pos=0",      encImmD(4, 3, 0, 0, 8),  A, B, 6'd5);
    step("R6 imm dword pos=40",     encImmD(4, 3, 0, 40, 8), A, B, 6'd5);
    step("R6 imm dword pos=20",     encImmD(4, 3, 0, 20, 8), A, B, 6'd5);
    step("R7 wrong opcode",         encSar(4, 3, 0, 0, 9) ^ 32'h0400_0000, A, B, 6'd8);
    step("R7 bad sar subfield",     encSar(4, 3, 0, 0, 9) | 32'h0000_0020, A, B, 6'd8);
    step("R7 sub-op 11 bit10=0",    encSar(4, 3, 0, 0, 9) | 32'h0000_1800, A, B, 6'd8);
    step("R8 R9 dword cond=5",      encSar(4, 3, 5, 1, 17), A, B, 6'd9);
    step("R8 imm dword narrow",     encImmD(4, 3, 7, 33, 30), A, B, 6'd9);
    step("R9 word cond=6 dest=31",  encImmW(4, 3, 6, 7, 31), A, B, 6'd9);

    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk); #1;
    checks++;
    if (wValid || nValid || wWrite) begin
      fails++;
      $display("FAIL R10 idle: valid=%0b write=%0b expected 0 0", wValid, wWrite);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule